// File: doc/BRIEF.md
# Long-Press Push-Button Reset Generator

This block turns one active-low push button into a system reset that only fires on a deliberate long press. The button has to stay pressed for a setup delay of 0.5 s to 10 s, chosen in half-second steps. Any shorter press, including a bounce or a glitch, never reaches the output. A short press can therefore serve as an ordinary interrupt elsewhere in the system, while a long press forces a hard reset.

Two pulse styles are available. In the button-driven style, reset lasts exactly as long as the button stays down after the delay. In the fixed style, reset lasts for one recovery time (1.28, 100, 210 or 360 ms), whatever the button does meanwhile. A test-request flag stands in for an overvoltage detector. The first request the block sees latches a test mode. The block then runs a 42 ms initial interval and gives a visible reset response. From then on every press uses the setup delay divided by 128. Only a new power-on reset leaves test mode.

All timing is counted in cycles of the `tick` enable, whose period is the parameter `TICK_US` in microseconds. The default is 10 µs. A larger value shortens every count, which keeps a simulation short. Each duration is the nominal time divided by `TICK_US`, rounded down, and never less than one tick.

Top module: `lpress_rst_gen`

## Requirements
- R1: After power-on reset (`rst` high, synchronous), the output is at its idle level and the block is in normal mode.
- R2: Reset asserts only after the button (`btn_n` = 0 means pressed) has been sampled pressed on D consecutive ticks, where D = SETUP_STEPS × (500000 / TICK_US) ticks and SETUP_STEPS is 1 to 20. With `tick` held high, a press that starts before clock edge k makes the output assert after edge k+D+1.
- R3: A press of fewer than D ticks never asserts the output. A release clears the hold count, so two short presses split by a one-cycle release do not add up.
- R4: In button-driven mode (FIXED_PULSE = 0), reset stays asserted while the button is held. It deasserts on the third clock edge after the first released sample.
- R5: In fixed mode (FIXED_PULSE = 1), reset stays asserted for exactly R ticks, whether the button is held or released. R = time / TICK_US, with the time picked by REC_SEL: 0 → 1280 µs, 1 → 100000 µs, 2 → 210000 µs, 3 → 360000 µs.
- R6: In fixed mode, a button still held after the pulse does not retrigger. A fresh release and a full new press are needed.
- R7: Only cycles with `tick` high advance any timer. A button held with `tick` low never asserts the output.
- R8: The first `test_req` = 1 seen latches test mode and starts an initial interval of I = 42000 / TICK_US ticks. The output asserts two edges after the final tick of that interval. Fixed mode then gives one R-tick pulse. Button-driven mode holds reset for as long as `test_req` stays 1.
- R9: In test mode the setup delay is max(1, D / 128) ticks, rounded down.
- R10: Test mode is sticky. A later `test_req` has no effect, and only `rst` returns the block to the normal delay.
- R11: ACTIVE_HIGH selects the polarity: 1 gives idle 0 and asserted 1, while 0 gives idle 1 and asserted 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Time-base enable, one pulse per TICK_US microseconds |
| btn_n | input | 1 | Push button, 0 = pressed, asynchronous |
| test_req | input | 1 | Test-mode request from an overvoltage detector, 1 = request, asynchronous |
| rst_out | output | 1 | Reset output, polarity set by ACTIVE_HIGH |

## Verification
The bench targets a press exactly one tick short of the delay and a press split by a single-cycle release. It also probes the one-cycle boundary where the output must first assert. A design that counts one tick late or early, or that keeps the count across a release, fails here. Fixed pulses are measured with the button both held and released mid-pulse, and the button is then kept down long after the pulse. This catches a design whose pulse tracks the button or that retriggers without a fresh press. Test mode is checked through its initial interval, its shortened delay, a second request that must do nothing, and a power-on reset that must restore the full delay. A design that clears the test latch too easily, or reruns the initial interval, shows up as a wrong assertion count.

// File: rtl/lprg_pkg.sv
package lprg_pkg;

    typedef enum logic [2:0] {
        S_ARMED,
        S_HELD,
        S_PULSE,
        S_WAIT_REL,
        S_TINIT,
        S_TREQ
    } lprg_state_t;

    localparam int unsigned HALF_SEC_US = 500000;
    localparam int unsigned INIT_US     = 42000;
    localparam int unsigned SHORT_DIV   = 128;
    localparam int unsigned MAX_STEPS   = 20;

    // Nominal microseconds to whole ticks, never below one tick.
    function automatic int unsigned ticks_of(input int unsigned us, input int unsigned tick_us);
        int unsigned q;
        q = us / tick_us;
        return (q == 0) ? 1 : q;
    endfunction

    function automatic int unsigned rec_us(input int unsigned sel);
        case (sel)
            0:       return 1280;
            1:       return 100000;
            2:       return 210000;
            default: return 360000;
        endcase
    endfunction

    function automatic int unsigned clamp_steps(input int unsigned s);
        if (s < 1) return 1;
        if (s > MAX_STEPS) return MAX_STEPS;
        return s;
    endfunction

    function automatic int unsigned short_of(input int unsigned full);
        return (full / SHORT_DIV == 0) ? 1 : full / SHORT_DIV;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic drives_reset(input lprg_state_t s);
        return (s == S_HELD) || (s == S_PULSE) || (s == S_TREQ);
    endfunction

endpackage

// File: rtl/lprg_sync.sv
module lprg_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta_q;
            logic out_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta_q <= 1'b0;
                    out_q  <= 1'b0;
                end else begin
                    meta_q <= d[i];
                    out_q  <= meta_q;
                end
            end
            assign q[i] = out_q;
        end
    endgenerate
endmodule

// File: rtl/lprg_ctrl.sv
module lprg_ctrl
    import lprg_pkg::*;
#(
    parameter int unsigned DLY_FULL    = 1000,
    parameter int unsigned DLY_SHORT   = 7,
    parameter int unsigned INIT_T      = 42,
    parameter int unsigned REC_T       = 100,
    parameter bit          FIXED_PULSE = 1'b0,
    parameter int unsigned CW          = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_act,
    input  logic treq_act,
    output logic assert_q
);
    localparam logic [CW-1:0] L_FULL  = CW'(DLY_FULL);
    localparam logic [CW-1:0] L_SHORT = CW'(DLY_SHORT);
    localparam logic [CW-1:0] L_INIT  = CW'(INIT_T);
    localparam logic [CW-1:0] L_REC   = CW'(REC_T);
    localparam logic [CW-1:0] L_MAX   = CW'(max3(DLY_FULL, INIT_T, REC_T));

    lprg_state_t   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d, cnt_inc, dly_lim;
    logic          test_q, test_d;
    logic          assert_d;
    logic          enter_test;

    assign cnt_inc    = cnt_q + CW'(1);
    assign dly_lim    = test_q ? L_SHORT : L_FULL;
    assign enter_test = treq_act && !test_q;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        test_d = test_q;
        if (enter_test) begin
            test_d = 1'b1;
            st_d   = S_TINIT;
            cnt_d  = '0;
        end else begin
            case (st_q)
                S_ARMED: begin
                    if (!btn_act) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_inc >= dly_lim) begin
                            cnt_d = '0;
                            st_d  = FIXED_PULSE ? S_PULSE : S_HELD;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                S_HELD: begin
                    if (!btn_act) st_d = S_ARMED;
                end
                S_PULSE: begin
                    if (tick) begin
                        if (cnt_inc >= L_REC) begin
                            cnt_d = '0;
                            st_d  = btn_act ? S_WAIT_REL : S_ARMED;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                S_WAIT_REL: begin
                    if (!btn_act) st_d = S_ARMED;
                end
                S_TINIT: begin
                    if (tick) begin
                        if (cnt_inc >= L_INIT) begin
                            cnt_d = '0;
                            if (FIXED_PULSE) st_d = S_PULSE;
                            else             st_d = treq_act ? S_TREQ : S_ARMED;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                S_TREQ: begin
                    if (!treq_act) st_d = S_ARMED;
                end
                default: begin
                    st_d  = S_ARMED;
                    cnt_d = '0;
                end
            endcase
        end
    end

    assign assert_d = drives_reset(st_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_ARMED;
            cnt_q    <= '0;
            test_q   <= 1'b0;
            assert_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            test_q   <= test_d;
            assert_q <= assert_d;
        end
    end

    // R2: the hold or interval counter never runs past its largest limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= L_MAX);

    // R2: a reset driven from the armed state needs a pressed sample one cycle earlier
    p_fire_needs_press_r2: assert property (@(posedge clk) disable iff (rst)
        ((st_q == S_HELD || st_q == S_PULSE) && $past(st_q) == S_ARMED) |-> $past(btn_act));

    // R4: a released button ends a button-driven reset on the next edge
    p_release_ends_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_HELD && !btn_act && !enter_test) |=> (st_q == S_ARMED && !assert_q));

    // R7: without a tick the timed states neither count nor move on
    p_tick_gate_r7: assert property (@(posedge clk) disable iff (rst)
        ((st_q == S_PULSE || st_q == S_TINIT) && !tick && !enter_test)
            |=> ($stable(cnt_q) && $stable(st_q)));

    // R10: the test latch stays set until power-on reset
    p_test_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        test_q |=> test_q);

    // R8: the request-driven hold exists only inside test mode
    p_treq_in_test_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_TREQ) |-> test_q);

endmodule

// File: rtl/lpress_rst_gen.sv
module lpress_rst_gen
    import lprg_pkg::*;
#(
    parameter int unsigned SETUP_STEPS = 20,
    parameter int unsigned TICK_US     = 10,
    parameter bit          FIXED_PULSE = 1'b0,
    parameter int unsigned REC_SEL     = 2,
    parameter bit          ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_n,
    input  logic test_req,
    output logic rst_out
);
    localparam int unsigned STEP_T    = ticks_of(HALF_SEC_US, TICK_US);
    localparam int unsigned DLY_FULL  = clamp_steps(SETUP_STEPS) * STEP_T;
    localparam int unsigned DLY_SHORT = short_of(DLY_FULL);
    localparam int unsigned INIT_T    = ticks_of(INIT_US, TICK_US);
    localparam int unsigned REC_T     = ticks_of(rec_us(REC_SEL), TICK_US);
    localparam int unsigned LIM_MAX   = max3(DLY_FULL, INIT_T, REC_T);
    localparam int unsigned CW        = $clog2(LIM_MAX + 1);
    localparam logic        IDLE_LVL  = !ACTIVE_HIGH;

    logic [1:0] raw_act, sync_act;
    logic       assert_q;

    assign raw_act = {test_req, ~btn_n};

    lprg_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_act),
        .q   (sync_act)
    );

    lprg_ctrl #(
        .DLY_FULL    (DLY_FULL),
        .DLY_SHORT   (DLY_SHORT),
        .INIT_T      (INIT_T),
        .REC_T       (REC_T),
        .FIXED_PULSE (FIXED_PULSE),
        .CW          (CW)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .btn_act  (sync_act[0]),
        .treq_act (sync_act[1]),
        .assert_q (assert_q)
    );

    generate
        if (ACTIVE_HIGH) begin : g_pol_high
            assign rst_out = assert_q;
        end else begin : g_pol_low
            assign rst_out = ~assert_q;
        end
    endgenerate

    // R1: the cycle after power-on reset the output sits at its idle level
    p_idle_after_por_r1: assert property (@(posedge clk)
        $past(rst) |-> (rst_out == IDLE_LVL));

endmodule

// File: tb/lpress_rst_gen_bench.sv
module lpress_rst_gen_bench;
    // Bench timing from the requirements: TICK_US = 2000, SETUP_STEPS = 2, REC_SEL = 1
    localparam int D  = 2 * (500000 / 2000);  // 500 ticks
    localparam int DS = D / 128;              // 3 ticks
    localparam int I  = 42000 / 2000;         // 21 ticks
    localparam int R  = 100000 / 2000;        // 50 ticks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic btn_n = 1'b1;
    logic test_req = 1'b0;
    logic out_a, out_b;
    int   total = 0;
    int   fails = 0;
    int   seen_a = 0;
    int   seen_b = 0;

    always #4 clk = ~clk;

    // A: button-driven, active-low output
    lpress_rst_gen #(.SETUP_STEPS(2), .TICK_US(2000), .FIXED_PULSE(1'b0),
                     .REC_SEL(1), .ACTIVE_HIGH(1'b0)) u_lpress_rst_gen (
        .clk(clk), .rst(rst), .tick(tick), .btn_n(btn_n),
        .test_req(test_req), .rst_out(out_a));

    // B: fixed pulse, active-high output
    lpress_rst_gen #(.SETUP_STEPS(2), .TICK_US(2000), .FIXED_PULSE(1'b1),
                     .REC_SEL(1), .ACTIVE_HIGH(1'b1)) u_lpress_rst_gen_fix (
        .clk(clk), .rst(rst), .tick(tick), .btn_n(btn_n),
        .test_req(test_req), .rst_out(out_b));

    function automatic int act_a();
        return (out_a == 1'b0) ? 1 : 0;
    endfunction
    function automatic int act_b();
        return (out_b == 1'b1) ? 1 : 0;
    endfunction
    function automatic int exp_a_cycles(input int len);
        return (len >= D) ? len - D + 1 : 0;
    endfunction
    function automatic int exp_b_cycles(input int len);
        return (len >= D) ? R : 0;
    endfunction

    always @(posedge clk) begin
        if (act_a() == 1) seen_a <= seen_a + 1;
        if (act_b() == 1) seen_b <= seen_b + 1;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_seen();
        seen_a = 0;
        seen_b = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'h5EED_0119);
        step(4);
        rst = 1'b0;
        step(1);
        // R1, R11: idle levels of both polarities after power-on
        chk("R1 R11 idle A", int'(out_a), 1);
        chk("R1 R11 idle B", int'(out_b), 0);

        // R3: press one tick short
        clear_seen();
        btn_n = 1'b0; step(D - 1); btn_n = 1'b1; step(R + 10);
        chk("R3 short press A", seen_a, 0);
        chk("R3 short press B", seen_b, 0);

        // R3: release clears the count
        clear_seen();
        btn_n = 1'b0; step(D - 1); btn_n = 1'b1; step(1);
        btn_n = 1'b0; step(D - 1); btn_n = 1'b1; step(R + 10);
        chk("R3 split press A", seen_a, 0);
        chk("R3 split press B", seen_b, 0);

        // R2 R4 R5 R6: long hold
        btn_n = 1'b0; step(D + 1);
        chk("R2 before edge A", act_a(), 0);
        chk("R2 before edge B", act_b(), 0);
        step(1);
        chk("R2 asserted A", act_a(), 1);
        chk("R2 asserted B", act_b(), 1);
        step(R - 1);
        chk("R5 last pulse cycle B", act_b(), 1);
        step(1);
        chk("R5 pulse ends while held B", act_b(), 0);
        chk("R4 still held A", act_a(), 1);
        clear_seen();
        step(D + 100);
        chk("R6 no retrigger B", seen_b, 0);
        chk("R4 held long A", act_a(), 1);
        btn_n = 1'b1; step(2);
        chk("R4 release lag A", act_a(), 1);
        step(1);
        chk("R4 release off A", act_a(), 0);
        step(5);

        // R5 R6: new press re-arms, release mid-pulse ignored
        btn_n = 1'b0; step(D + 2);
        chk("R6 re-arm B", act_b(), 1);
        btn_n = 1'b1; step(2);
        chk("R4 lag A", act_a(), 1);
        step(1);
        chk("R4 off A", act_a(), 0);
        step(R - 4);
        chk("R5 released still on B", act_b(), 1);
        step(1);
        chk("R5 off after R B", act_b(), 0);
        step(10);

        // R7: no tick, no progress
        clear_seen();
        tick = 1'b0; btn_n = 1'b0; step(2 * D);
        chk("R7 no tick A", seen_a, 0);
        chk("R7 no tick B", seen_b, 0);
        tick = 1'b1; step(D - 1);
        chk("R7 ticks resume early A", act_a(), 0);
        step(1);
        chk("R7 ticks resume A", act_a(), 1);
        chk("R7 ticks resume B", act_b(), 1);
        btn_n = 1'b1; step(R + 10);

        // R2 R3: random lengths around the delay
        for (int n = 0; n < 10; n++) begin
            int len;
            len = D - 20 + int'($urandom_range(40));
            clear_seen();
            btn_n = 1'b0; step(len); btn_n = 1'b1; step(R + 10);
            chk($sformatf("R2 random len %0d A", len), seen_a, exp_a_cycles(len));
            chk($sformatf("R3 random len %0d B", len), seen_b, exp_b_cycles(len));
        end

        // R8: test mode entry
        test_req = 1'b1; step(I + 2);
        chk("R8 init running A", act_a(), 0);
        chk("R8 init running B", act_b(), 0);
        step(1);
        chk("R8 after init A", act_a(), 1);
        chk("R8 after init B", act_b(), 1);
        step(R - 1);
        chk("R8 pulse on B", act_b(), 1);
        step(1);
        chk("R8 pulse off B", act_b(), 0);
        step(7);
        chk("R8 held by request A", act_a(), 1);
        test_req = 1'b0; step(2);
        chk("R8 request lag A", act_a(), 1);
        step(1);
        chk("R8 request off A", act_a(), 0);
        step(5);

        // R9: shortened delay
        clear_seen();
        btn_n = 1'b0; step(DS - 1); btn_n = 1'b1; step(R + 10);
        chk("R9 short-short A", seen_a, 0);
        chk("R9 short-short B", seen_b, 0);
        btn_n = 1'b0; step(DS + 1);
        chk("R9 before edge A", act_a(), 0);
        step(1);
        chk("R9 fired A", act_a(), 1);
        chk("R9 fired B", act_b(), 1);
        btn_n = 1'b1; step(3);
        chk("R9 release A", act_a(), 0);
        step(R + 10);

        // R10: second request does nothing
        clear_seen();
        test_req = 1'b1; step(I + R + 10); test_req = 1'b0; step(5);
        chk("R10 re-request A", seen_a, 0);
        chk("R10 re-request B", seen_b, 0);

        // R10 R1: power-on reset restores normal delay
        rst = 1'b1; step(3); rst = 1'b0; step(1);
        chk("R1 idle after por A", int'(out_a), 1);
        chk("R1 idle after por B", int'(out_b), 0);
        btn_n = 1'b0; step(DS + 2);
        chk("R10 short delay gone A", act_a(), 0);
        chk("R10 short delay gone B", act_b(), 0);
        step(D + 1 - (DS + 2));
        chk("R10 normal edge A", act_a(), 0);
        step(1);
        chk("R10 normal fire A", act_a(), 1);
        chk("R10 normal fire B", act_b(), 1);
        btn_n = 1'b1; step(R + 10);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule